// File: doc/BRIEF.md
# Power Mode Inactivity Sequencer

This block decides which of six power modes a system is in. Out of reset it sits in the full-speed mode. Each stretch of inactivity that lasts long enough moves it one step down the ladder of modes: full-speed clock, reduced-speed clock, doze, sleep, suspend and finally off. Each step has its own programmable delay. Any activity event that passes the software activity mask sends the block straight back to full speed and restarts the timing. The off mode is left only through a dedicated wake input or a reset.

Every step delay is an 8-bit count N, read as N+1 units of a base period for that step. The base periods come from a chain of prescalers driven by a time-base tick. The divisors are parameters: the defaults give a 1/512 s tick the real-time units 1/16 s, 1/2 s, 4 s and 60 s, and a bench can shrink them. Two steps let software choose between a short and a long unit. When external AC power is reported, either on a pin or by a software bit, power management is switched off. The block is then pinned to full speed and its timers are held at zero.

Downstream clock-gating and rail-control logic read the mode code. They use the entry strobe to start their own sequencing.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous active-low reset, `mode` is 0 (full speed) and `mode_entry` is 0.
- R2: Full speed steps to reduced speed after (`to_hs`+1) units: tick periods when `rng_hs`=0, and 1st-prescaler periods (1/16 s with the default divisors) when `rng_hs`=1.
- R3: Reduced speed steps to doze after (`to_ls`+1) units: 1st-prescaler periods when `rng_ls`=0, and 2nd-prescaler periods (1/2 s with the default divisors) when `rng_ls`=1.
- R4: Doze steps to sleep after (`to_doze`+1) 3rd-prescaler periods (4 s). Sleep steps to suspend after (`to_sleep`+1) 1st-prescaler periods. Suspend steps to off after (`to_susp`+1) 4th-prescaler periods (60 s).
- R5: An `act_ev` bit counts as activity only when the same bit of `act_mask` is 1. A masked-off event changes neither the mode nor the running timeout.
- R6: In any mode except off, an unmasked activity event moves the mode to 0 at the next edge and restarts the timeout from zero.
- R7: While `ac_pin` or `ac_sw` is 1, the mode is forced to 0 at the next edge and all timing is held cleared. Timing starts from zero once both are 0.
- R8: In off (code 5), activity events are ignored. Only `wake` (or an active AC indication) returns the mode to 0.
- R9: `mode_entry` is 1 for exactly the one cycle in which a new mode value first appears, and 0 in every other cycle.
- R10: When an unmasked activity event falls in the same cycle as a timeout expiry, the activity wins: the mode becomes (or stays) 0 and the timeout restarts.
- R11: Mode codes are 0 full speed, 1 reduced speed, 2 doze, 3 sleep, 4 suspend, 5 off. A step down always moves to the next code, one code at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base strobe, one cycle per base tick |
| act_ev | input | ACT_W | Activity event vector |
| act_mask | input | ACT_W | Per-bit activity enable |
| ac_pin | input | 1 | External AC power present |
| ac_sw | input | 1 | Software AC-present override |
| wake | input | 1 | Wake request, used only in off |
| rng_hs | input | 1 | Long-unit select for the full-speed step |
| rng_ls | input | 1 | Long-unit select for the reduced-speed step |
| to_hs | input | TO_W | Full-speed timeout count |
| to_ls | input | TO_W | Reduced-speed timeout count |
| to_doze | input | TO_W | Doze timeout count |
| to_sleep | input | TO_W | Sleep timeout count |
| to_susp | input | TO_W | Suspend timeout count |
| mode | output | 3 | Current mode code |
| mode_entry | output | 1 | One-cycle strobe on entry to a new mode |

## Verification
The interesting collision is an activity event that lands in the exact cycle in which the inactivity count reaches its limit. The bench counts edges from a known restart and asserts the event in that final cycle. It does this once in reduced speed, where the mode must fall back to 0 with an entry strobe, and once in full speed, where the mode must stay at 0 with no strobe. It then times a full dwell afterwards. That dwell only comes out right if the timeout restarted rather than expired.

// File: rtl/pms_pkg.sv
// Package: shared types for the power mode inactivity sequencer.
// Assumes a 3-bit mode code whose numeric order is the descent order.
package pms_pkg;
    typedef enum logic [2:0] {
        M_HS    = 3'd0,
        M_LS    = 3'd1,
        M_DOZE  = 3'd2,
        M_SLEEP = 3'd3,
        M_SUSP  = 3'd4,
        M_OFF   = 3'd5
    } mode_e;

    localparam int NUM_UNITS = 5;
endpackage

// File: rtl/pms_prescale.sv
// Prescaler chain: turns the base tick into NUM_UNITS unit strobes.
// Stage 0 is the tick itself; stage k pulses once every DIVk pulses of
// stage k-1. Assumes every divisor is at least 2. A synchronous clear
// returns every stage to its start so a new timeout begins on a clean unit.
module pms_prescale
    import pms_pkg::*;
#(
    parameter int DIV1 = 32,
    parameter int DIV2 = 8,
    parameter int DIV3 = 8,
    parameter int DIV4 = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 tick,
    output logic [NUM_UNITS-1:0] unit_stb
);
    function automatic int stage_div(input int k);
        case (k)
            1:       return DIV1;
            2:       return DIV2;
            3:       return DIV3;
            default: return DIV4;
        endcase
    endfunction

    assign unit_stb[0] = tick;

    for (genvar k = 1; k < NUM_UNITS; k++) begin : g_stage
        localparam int D  = stage_div(k);
        localparam int CW = (D > 2) ? $clog2(D) : 1;
        logic [CW-1:0] cnt;

        // Count lower-stage strobes, wrap at D-1, clear on restart.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt <= '0;
            else if (unit_stb[k-1])
                cnt <= (cnt == CW'(D - 1)) ? '0 : cnt + 1'b1;
        end

        assign unit_stb[k] = unit_stb[k-1] && (cnt == CW'(D - 1));
    end
endmodule

// File: rtl/pms_idle_timer.sv
// Inactivity timer: picks the unit strobe and limit for the current mode
// and counts units. It flags expiry on the (limit+1)-th unit. Assumes the
// caller clears it on restart or expiry through clr. Off has no timeout.
module pms_idle_timer
    import pms_pkg::*;
#(
    parameter int TO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  mode_e                mode,
    input  logic [NUM_UNITS-1:0] unit_stb,
    input  logic                 rng_hs,
    input  logic                 rng_ls,
    input  logic [TO_W-1:0]      to_hs,
    input  logic [TO_W-1:0]      to_ls,
    input  logic [TO_W-1:0]      to_doze,
    input  logic [TO_W-1:0]      to_sleep,
    input  logic [TO_W-1:0]      to_susp,
    output logic                 expire
);
    logic            stb;
    logic [TO_W-1:0] lim;
    logic [TO_W-1:0] icnt;

    // Select this mode's unit strobe and timeout limit.
    always_comb begin
        stb = 1'b0;
        lim = '0;
        case (mode)
            M_HS:    begin stb = rng_hs ? unit_stb[1] : unit_stb[0]; lim = to_hs;    end
            M_LS:    begin stb = rng_ls ? unit_stb[2] : unit_stb[1]; lim = to_ls;    end
            M_DOZE:  begin stb = unit_stb[3];                        lim = to_doze;  end
            M_SLEEP: begin stb = unit_stb[1];                        lim = to_sleep; end
            M_SUSP:  begin stb = unit_stb[4];                        lim = to_susp;  end
            default: begin stb = 1'b0;                               lim = '0;       end
        endcase
    end

    assign expire = stb && (icnt == lim);

    // Count elapsed units since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            icnt <= '0;
        else if (stb)
            icnt <= icnt + 1'b1;
    end
endmodule

// File: rtl/pms_mode_fsm.sv
// Mode state machine. Priority order: AC disable, then the off/wake rule,
// then activity, then timeout expiry. Asserts restart whenever timing must
// be held or restarted. Registers a one-cycle strobe on any mode change.
module pms_mode_fsm
    import pms_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pm_dis,
    input  logic  act_hit,
    input  logic  wake,
    input  logic  expire,
    output mode_e mode,
    output logic  mode_entry,
    output logic  restart
);
    mode_e nxt;

    // Timing is held cleared when disabled, in off, or on activity.
    assign restart = pm_dis || (mode == M_OFF) || act_hit;

    // Choose the next mode by fixed priority.
    always_comb begin
        nxt = mode;
        if (pm_dis)
            nxt = M_HS;
        else if (mode == M_OFF)
            nxt = wake ? M_HS : M_OFF;
        else if (act_hit)
            nxt = M_HS;
        else if (expire)
            nxt = mode_e'(mode + 3'd1);
    end

    // Hold the mode and raise the entry strobe on change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= M_HS;
            mode_entry <= 1'b0;
        end else begin
            mode       <= nxt;
            mode_entry <= (nxt != mode);
        end
    end
endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the power mode inactivity sequencer. It masks activity, merges the
// two AC indications, and wires the prescaler chain, the inactivity timer
// and the mode machine together. Assumes all inputs are synchronous to clk.
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int TO_W  = 8,
    parameter int DIV1  = 32,
    parameter int DIV2  = 8,
    parameter int DIV3  = 8,
    parameter int DIV4  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ACT_W-1:0] act_ev,
    input  logic [ACT_W-1:0] act_mask,
    input  logic             ac_pin,
    input  logic             ac_sw,
    input  logic             wake,
    input  logic             rng_hs,
    input  logic             rng_ls,
    input  logic [TO_W-1:0]  to_hs,
    input  logic [TO_W-1:0]  to_ls,
    input  logic [TO_W-1:0]  to_doze,
    input  logic [TO_W-1:0]  to_sleep,
    input  logic [TO_W-1:0]  to_susp,
    output logic [2:0]       mode,
    output logic             mode_entry
);
    logic                 act_hit;
    logic                 pm_dis;
    logic                 restart;
    logic                 expire;
    logic                 tclr;
    logic [NUM_UNITS-1:0] unit_stb;
    mode_e                mode_q;

    assign act_hit = |(act_ev & act_mask);
    assign pm_dis  = ac_pin || ac_sw;
    assign tclr    = restart || expire;
    assign mode    = mode_q;

    pms_prescale #(
        .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .DIV4(DIV4)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tclr),
        .tick     (tick),
        .unit_stb (unit_stb)
    );

    pms_idle_timer #(.TO_W(TO_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tclr),
        .mode     (mode_q),
        .unit_stb (unit_stb),
        .rng_hs   (rng_hs),
        .rng_ls   (rng_ls),
        .to_hs    (to_hs),
        .to_ls    (to_ls),
        .to_doze  (to_doze),
        .to_sleep (to_sleep),
        .to_susp  (to_susp),
        .expire   (expire)
    );

    pms_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pm_dis     (pm_dis),
        .act_hit    (act_hit),
        .wake       (wake),
        .expire     (expire),
        .mode       (mode_q),
        .mode_entry (mode_entry),
        .restart    (restart)
    );
endmodule

// File: rtl/pms_checker.sv
// Checker for the power mode inactivity sequencer: port-level temporal
// properties, attached to every instance of the top by the bind below.
module pms_checker #(
    parameter int ACT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACT_W-1:0] act_ev,
    input logic [ACT_W-1:0] act_mask,
    input logic             ac_pin,
    input logic             ac_sw,
    input logic             wake,
    input logic [2:0]       mode,
    input logic             mode_entry
);
    AST_AC_FORCES_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_pin || ac_sw) |=> (mode == 3'd0)); // R7

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !wake && !ac_pin && !ac_sw) |=> (mode == 3'd5)); // R8

    AST_ACT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd5 && (act_ev & act_mask) != '0) |=> (mode == 3'd0)); // R6

    AST_ENTRY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> mode_entry); // R9

    AST_NO_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == $past(mode)) |-> !mode_entry); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode) && mode != 3'd0) |-> (mode == 3'($past(mode) + 3'd1))); // R11

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd5); // R11
endmodule

bind pwr_mode_seq pms_checker #(.ACT_W(ACT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_ev     (act_ev),
    .act_mask   (act_mask),
    .ac_pin     (ac_pin),
    .ac_sw      (ac_sw),
    .wake       (wake),
    .mode       (mode),
    .mode_entry (mode_entry)
);

// File: tb/pwr_mode_seq_bench.sv
// Directed bench. Divisors 2,2,2,3 with the tick held high give unit
// periods of 1, 2, 4, 8 and 24 cycles.
module pwr_mode_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [7:0] act_ev = '0;
    logic [7:0] act_mask = 8'hFF;
    logic       ac_pin = 1'b0, ac_sw = 1'b0, wake = 1'b0;
    logic       rng_hs = 1'b0, rng_ls = 1'b0;
    logic [7:0] to_hs = 8'd3, to_ls = 8'd2, to_doze = 8'd1, to_sleep = 8'd0, to_susp = 8'd0;
    logic [2:0] mode;
    logic       mode_entry;
    int         n_chk = 0;
    int         n_err = 0;

    always #2 clk = ~clk;

    pwr_mode_seq #(.DIV1(2), .DIV2(2), .DIV3(2), .DIV4(3)) u_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .act_ev(act_ev), .act_mask(act_mask),
        .ac_pin(ac_pin), .ac_sw(ac_sw), .wake(wake), .rng_hs(rng_hs), .rng_ls(rng_ls),
        .to_hs(to_hs), .to_ls(to_ls), .to_doze(to_doze), .to_sleep(to_sleep),
        .to_susp(to_susp), .mode(mode), .mode_entry(mode_entry)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stay in cur for n-1 samples, then see next with an entry strobe.
    task automatic dwell(input int cur, input int n, input int nxt, input string tag);
        edges(n - 1);
        check(mode, cur, {tag, " mode before expiry"});
        check(mode_entry, 0, {tag, " R9 no strobe while dwelling"});
        edges(1);
        check(mode, nxt, {tag, " mode after expiry"});
        check(mode_entry, 1, {tag, " R9 strobe on entry"});
    endtask

    task automatic t_reset;
        check(mode, 0, "R1 reset mode");
        check(mode_entry, 0, "R1 reset strobe");
    endtask

    task automatic t_descent;
        dwell(0, 4, 1, "R2 short range");
        dwell(1, 6, 2, "R3 short range");
        dwell(2, 16, 3, "R4 doze");
        dwell(3, 2, 4, "R4 sleep");
        dwell(4, 24, 5, "R4 suspend R11");
    endtask

    task automatic t_off;
        act_ev = 8'h02;
        edges(1);
        act_ev = 8'h00;
        edges(10);
        check(mode, 5, "R8 activity ignored in off");
        check(mode_entry, 0, "R8 no strobe in off");
        wake = 1'b1;
        edges(1);
        wake = 1'b0;
        check(mode, 0, "R8 wake leaves off");
        check(mode_entry, 1, "R9 strobe on wake");
    endtask

    task automatic t_range;
        rng_hs = 1'b1; rng_ls = 1'b1; to_hs = 8'd2; to_ls = 8'd1;
        dwell(0, 6, 1, "R2 long range");
        dwell(1, 8, 2, "R3 long range");
    endtask

    task automatic t_ac;
        ac_pin = 1'b1;
        edges(1);
        check(mode, 0, "R7 pin forces full speed");
        check(mode_entry, 1, "R7 strobe on forced entry");
        edges(30);
        check(mode, 0, "R7 held by pin");
        ac_pin = 1'b0; ac_sw = 1'b1;
        edges(30);
        check(mode, 0, "R7 held by software bit");
        ac_sw = 1'b0;
        dwell(0, 6, 1, "R7 timing restarts after release");
        rng_hs = 1'b0; rng_ls = 1'b0; to_hs = 8'd3; to_ls = 8'd2;
    endtask

    task automatic t_mask;
        act_mask = 8'hFE;
        act_ev = 8'h01;
        edges(1);
        act_ev = 8'h00;
        check(mode, 1, "R5 masked event ignored");
        dwell(1, 5, 2, "R5 timeout undisturbed");
        act_mask = 8'hFF;
    endtask

    task automatic t_act;
        edges(3);
        act_ev = 8'h02;
        edges(1);
        act_ev = 8'h00;
        check(mode, 0, "R6 activity returns to full speed");
        check(mode_entry, 1, "R6 strobe on return");
        dwell(0, 4, 1, "R6 timeout restarted");
    endtask

    task automatic t_collide;
        edges(5);
        act_ev = 8'h80;
        edges(1);
        act_ev = 8'h00;
        check(mode, 0, "R10 activity beats expiry in reduced speed");
        check(mode_entry, 1, "R10 strobe on return");
        edges(3);
        act_ev = 8'h80;
        edges(1);
        act_ev = 8'h00;
        check(mode, 0, "R10 activity beats expiry in full speed");
        check(mode_entry, 0, "R10 no strobe when staying");
        dwell(0, 4, 1, "R10 timeout restarted");
    endtask

    initial begin
        edges(4);
        rst_n = 1'b1;
        t_reset();
        t_descent();
        t_off();
        t_range();
        t_ac();
        t_mask();
        t_act();
        t_collide();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule